// File: doc/BRIEF.md
# Registered Fixed-Point Multiplier with Shared-Bus Result Ports

This block multiplies two operands and presents the double-width result on two 16-bit buses. Each operand carries its own format bit, so that a value is read either as two's complement or as unsigned magnitude. Mixed-format products therefore come out correctly. The operands, their format bits and a round request are held in input registers. The two halves of the product (high word and low word) are held in a pair of output registers. All of these registers share one clock, and each group has an active-low load enable. A transparent mode bypasses the output registers, so the product reaches the buses without waiting for a clock edge.

A format bit picks between two layouts. The first is the full-width product. The second drops the redundant sign bit of a fractional two's complement product and copies the sign into the top bit of the low word. The round request adds one at the top bit of the low word, and that position moves with the layout.

The high or the low word is steered onto a dedicated output bus. The low word can also be read back over a bidirectional bus, and that bus is the same one the second operand arrives on. Each bus is modelled as a data value plus a drive-enable output, and each drive enable follows an active-low output-enable input.

Top module: `regmul_bus_wrap`

## Requirements
- R1: On a rising clock edge with `x_ld_n` low, `x_in` and `x_tc` are stored; with `x_ld_n` high the stored X operand and its format bit keep their values.
- R2: On a rising clock edge with `y_ld_n` low, the value on `shr_in` and `y_tc` are stored; with `y_ld_n` high the stored Y operand and its format bit keep their values.
- R3: The round request `rnd_in` is stored on every edge at which either operand loads, and is held when neither loads.
- R4: An operand whose format bit is 1 is read as two's complement, and 0 means unsigned. With `full_fmt` = 1 the high word is product bits 31..16 and the low word bits 15..0. A stored round request adds 2^15 before the split.
- R5: With `full_fmt` = 0 the high word is product bits 30..15, and the low word is product bit 30 followed by bits 14..0. A stored round request adds 2^14 before the split.
- R6: On a rising edge with `p_ld_n` low, both output registers take the current product together; with `p_ld_n` high both hold.
- R7: With `transparent` = 1 both result words follow the current product with no clock edge needed; with `transparent` = 0 they show the output registers.
- R8: With `lo_sel` = 0, `ded_out` carries the high word; with `lo_sel` = 1 it carries the low word. `shr_out` always carries the low word.
- R9: `ded_drv` is the inverse of `ded_oe_n` and `shr_drv` is the inverse of `shr_oe_n`. A Y load needs `shr_oe_n` high, which leaves the shared bus undriven.
- R10: While `rst_n` is low, every register is zero; with `transparent` = 0, both result words then read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in | input | 16 | X operand |
| x_tc | input | 1 | X format: 1 two's complement, 0 unsigned |
| y_tc | input | 1 | Y format: 1 two's complement, 0 unsigned |
| rnd_in | input | 1 | Round request |
| x_ld_n | input | 1 | Active-low load of X register |
| y_ld_n | input | 1 | Active-low load of Y register |
| p_ld_n | input | 1 | Active-low load of both result registers |
| full_fmt | input | 1 | 1 full product, 0 sign-dropped layout |
| transparent | input | 1 | 1 makes result registers transparent |
| lo_sel | input | 1 | Dedicated bus word select: 0 high, 1 low |
| shr_oe_n | input | 1 | Active-low drive enable of shared bus |
| ded_oe_n | input | 1 | Active-low drive enable of dedicated bus |
| shr_in | input | 16 | Value present on shared bus (Y operand) |
| shr_out | output | 16 | Low word driven toward shared bus |
| shr_drv | output | 1 | Shared bus drive enable |
| ded_out | output | 16 | Word driven toward dedicated bus |
| ded_drv | output | 1 | Dedicated bus drive enable |

## Verification
The bench builds the block with its default operand width of 16. At that width, hand-checkable corner values are within reach. These are the largest unsigned square, a negative operand times an all-ones unsigned operand, and a round carry that ripples from the low word into the high word. They also include fractional products whose sign must appear in both words under the sign-dropped layout. The 16-bit width also makes the bit positions named in R4 and R5 literal, so the expected words are computed directly from those statements.

// File: rtl/regmul_pkg.sv
package regmul_pkg;
  parameter int unsigned OPW_DEF = 16;

  typedef enum logic {
    SEL_HI = 1'b0,
    SEL_LO = 1'b1
  } ded_sel_e;
endpackage

// File: rtl/regmul_opnd_reg.sv
module regmul_opnd_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  input  logic         tc_d,
  output logic [W-1:0] q,
  output logic         tc_q
);
  logic [W-1:0] q_nxt;
  logic         tc_nxt;

  always_comb begin
    q_nxt  = q;
    tc_nxt = tc_q;
    if (!ld_n) begin
      q_nxt  = d;
      tc_nxt = tc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      tc_q <= 1'b0;
    end else begin
      q    <= q_nxt;
      tc_q <= tc_nxt;
    end
  end

  AST_OPND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> (q == $past(d)) && (tc_q == $past(tc_d))); // R1, R2
  AST_OPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(q) && $stable(tc_q)); // R1, R2
endmodule

// File: rtl/regmul_core.sv
module regmul_core #(
  parameter int unsigned OPW = 16
) (
  input  logic [OPW-1:0] xa,
  input  logic           xa_tc,
  input  logic [OPW-1:0] ya,
  input  logic           ya_tc,
  input  logic           rnd,
  input  logic           full_fmt,
  output logic [OPW-1:0] hi_w,
  output logic [OPW-1:0] lo_w
);
  localparam int unsigned EW = OPW + 1;
  localparam int unsigned PW = 2 * OPW;

  logic signed [EW-1:0] xe, ye;
  logic signed [PW-1:0] xw, yw, pprod;
  logic        [PW-1:0] rnd_add, psum;

  assign xe    = {xa_tc & xa[OPW-1], xa};
  assign ye    = {ya_tc & ya[OPW-1], ya};
  assign xw    = PW'(xe);
  assign yw    = PW'(ye);
  assign pprod = xw * yw;

  always_comb begin
    rnd_add = '0;
    if (rnd) begin
      if (full_fmt) rnd_add[OPW-1] = 1'b1;
      else          rnd_add[OPW-2] = 1'b1;
    end
    psum = pprod + rnd_add;
  end

  always_comb begin
    if (full_fmt) begin
      hi_w = psum[PW-1:OPW];
      lo_w = psum[OPW-1:0];
    end else begin
      hi_w = psum[PW-2:OPW-1];
      lo_w = {psum[PW-2], psum[OPW-2:0]};
    end
  end

  always_comb begin
    if (!full_fmt) AST_SIGN_COPY: assert (lo_w[OPW-1] == hi_w[OPW-1]); // R5
  end
endmodule

// File: rtl/regmul_out_stage.sv
module regmul_out_stage
  import regmul_pkg::*;
#(
  parameter int unsigned OPW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           p_ld_n,
  input  logic           transparent,
  input  logic           lo_sel,
  input  logic [OPW-1:0] hi_c,
  input  logic [OPW-1:0] lo_c,
  output logic [OPW-1:0] ded_val,
  output logic [OPW-1:0] lo_val
);
  logic [OPW-1:0] hi_q, lo_q, hi_nxt, lo_nxt, hi_val;

  always_comb begin
    hi_nxt = hi_q;
    lo_nxt = lo_q;
    if (!p_ld_n) begin
      hi_nxt = hi_c;
      lo_nxt = lo_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
    end
  end

  assign hi_val  = transparent ? hi_c : hi_q;
  assign lo_val  = transparent ? lo_c : lo_q;
  assign ded_val = (ded_sel_e'(lo_sel) == SEL_LO) ? lo_val : hi_val;

  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    p_ld_n |=> $stable(hi_q) && $stable(lo_q)); // R6
  AST_PROD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !p_ld_n |=> (hi_q == $past(hi_c)) && (lo_q == $past(lo_c))); // R6
  AST_LO_ON_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    lo_sel |-> ded_val == lo_val); // R8
endmodule

// File: rtl/regmul_bus_wrap.sv
module regmul_bus_wrap
  import regmul_pkg::*;
#(
  parameter int unsigned OPW = OPW_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] x_in,
  input  logic           x_tc,
  input  logic           y_tc,
  input  logic           rnd_in,
  input  logic           x_ld_n,
  input  logic           y_ld_n,
  input  logic           p_ld_n,
  input  logic           full_fmt,
  input  logic           transparent,
  input  logic           lo_sel,
  input  logic           shr_oe_n,
  input  logic           ded_oe_n,
  input  logic [OPW-1:0] shr_in,
  output logic [OPW-1:0] shr_out,
  output logic           shr_drv,
  output logic [OPW-1:0] ded_out,
  output logic           ded_drv
);
  logic [OPW-1:0] xa, ya, hi_c, lo_c;
  logic           xa_tc, ya_tc;
  logic           rnd_q, rnd_nxt;

  regmul_opnd_reg #(.W(OPW)) u_xreg (
    .clk(clk), .rst_n(rst_n), .ld_n(x_ld_n), .d(x_in), .tc_d(x_tc),
    .q(xa), .tc_q(xa_tc)
  );

  regmul_opnd_reg #(.W(OPW)) u_yreg (
    .clk(clk), .rst_n(rst_n), .ld_n(y_ld_n), .d(shr_in), .tc_d(y_tc),
    .q(ya), .tc_q(ya_tc)
  );

  always_comb begin
    rnd_nxt = rnd_q;
    if (!x_ld_n || !y_ld_n) rnd_nxt = rnd_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd_q <= 1'b0;
    else        rnd_q <= rnd_nxt;
  end

  regmul_core #(.OPW(OPW)) u_core (
    .xa(xa), .xa_tc(xa_tc), .ya(ya), .ya_tc(ya_tc), .rnd(rnd_q),
    .full_fmt(full_fmt), .hi_w(hi_c), .lo_w(lo_c)
  );

  regmul_out_stage #(.OPW(OPW)) u_out (
    .clk(clk), .rst_n(rst_n), .p_ld_n(p_ld_n), .transparent(transparent),
    .lo_sel(lo_sel), .hi_c(hi_c), .lo_c(lo_c),
    .ded_val(ded_out), .lo_val(shr_out)
  );

  assign ded_drv = ~ded_oe_n;
  assign shr_drv = ~shr_oe_n;

  AST_RND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_ld_n || !y_ld_n) |=> rnd_q == $past(rnd_in)); // R3
  AST_RND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (x_ld_n && y_ld_n) |=> $stable(rnd_q)); // R3
  AST_NO_DRIVE_ON_YLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!y_ld_n && shr_oe_n) |-> !shr_drv); // R9
endmodule

// File: tb/regmul_bus_wrap_test.sv
module regmul_bus_wrap_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] x_in, shr_in;
  logic        x_tc, y_tc, rnd_in, x_ld_n, y_ld_n, p_ld_n;
  logic        full_fmt, transparent, lo_sel, shr_oe_n, ded_oe_n;
  logic [15:0] shr_out, ded_out;
  logic        shr_drv, ded_drv;
  int          n_chk = 0;
  int          n_err = 0;

  always #5 clk = ~clk;

  regmul_bus_wrap uut (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .x_tc(x_tc), .y_tc(y_tc),
    .rnd_in(rnd_in), .x_ld_n(x_ld_n), .y_ld_n(y_ld_n), .p_ld_n(p_ld_n),
    .full_fmt(full_fmt), .transparent(transparent), .lo_sel(lo_sel),
    .shr_oe_n(shr_oe_n), .ded_oe_n(ded_oe_n), .shr_in(shr_in),
    .shr_out(shr_out), .shr_drv(shr_drv), .ded_out(ded_out), .ded_drv(ded_drv)
  );

  function automatic logic [31:0] model(logic [15:0] x, bit xt, logic [15:0] y,
                                        bit yt, bit r, bit fa);
    longint xv = xt ? longint'($signed(x)) : longint'(x);
    longint yv = yt ? longint'($signed(y)) : longint'(y);
    longint p  = xv * yv + (r ? (fa ? 64'd32768 : 64'd16384) : 64'd0);
    logic [31:0] b = p[31:0];
    return fa ? b : {b[30:15], b[30], b[14:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_words(string req, logic [31:0] exp);
    lo_sel = 1'b0;
    #1;
    check(req, {ded_out, shr_out}, exp);
  endtask

  task automatic load_pair(logic [15:0] x, bit xt, logic [15:0] y, bit yt, bit r, bit fa);
    full_fmt = fa; x_in = x; x_tc = xt; shr_in = y; y_tc = yt; rnd_in = r;
    shr_oe_n = 1'b1; x_ld_n = 1'b0; y_ld_n = 1'b0;
    step();
    check("R9 shared bus undriven during Y load", {31'd0, shr_drv}, 32'd0);
    x_ld_n = 1'b1; y_ld_n = 1'b1; p_ld_n = 1'b0;
    step();
    p_ld_n = 1'b1; shr_oe_n = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; x_in = '0; shr_in = '0; x_tc = 0; y_tc = 0; rnd_in = 0;
    x_ld_n = 1; y_ld_n = 1; p_ld_n = 1; full_fmt = 1; transparent = 0;
    lo_sel = 0; shr_oe_n = 0; ded_oe_n = 0;
    step(); step();
    check("R10 reset words", {ded_out, shr_out}, 32'd0);
    check("R9 drives enabled", {30'd0, ded_drv, shr_drv}, 32'd3);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_arith();
    load_pair(16'hFFFF, 0, 16'hFFFF, 0, 0, 1);
    check_words("R4 unsigned max square", 32'hFFFE0001);
    load_pair(16'hFFFE, 1, 16'h0003, 1, 0, 1);
    check_words("R4 signed", 32'hFFFFFFFA);
    load_pair(16'hFFFF, 1, 16'hFFFF, 0, 0, 1);
    check_words("R4 mixed", 32'hFFFF0001);
    load_pair(16'h0001, 0, 16'h8000, 0, 1, 1);
    check_words("R4 round carry", 32'h00010000);
  endtask

  task automatic t_shift();
    load_pair(16'h4000, 1, 16'h4000, 1, 1, 0);
    check_words("R5 positive rounded", model(16'h4000, 1, 16'h4000, 1, 1, 0));
    load_pair(16'hC000, 1, 16'h4000, 1, 0, 0);
    check_words("R5 negative sign copy", 32'hE0008000);
    load_pair(16'h8000, 1, 16'h7FFF, 1, 0, 0);
    check_words("R5 most negative", model(16'h8000, 1, 16'h7FFF, 1, 0, 0));
  endtask

  task automatic t_hold_ops();
    load_pair(16'd3, 0, 16'd5, 0, 0, 1);
    x_in = 16'd7; x_tc = 1; shr_in = 16'd9; shr_oe_n = 1;
    x_ld_n = 1; y_ld_n = 0;
    step();
    y_ld_n = 1; p_ld_n = 0;
    step();
    p_ld_n = 1; shr_oe_n = 0;
    check_words("R1 X held", 32'd27);
    x_in = 16'd2; shr_in = 16'd11; x_ld_n = 0; shr_oe_n = 1;
    step();
    x_ld_n = 1; p_ld_n = 0;
    step();
    p_ld_n = 1; shr_oe_n = 0;
    check_words("R2 Y held", 32'd18);
  endtask

  task automatic t_round_reg();
    load_pair(16'd1, 0, 16'h8000, 0, 1, 1);
    rnd_in = 0; p_ld_n = 0;
    step();
    p_ld_n = 1;
    check_words("R3 round held", 32'h00010000);
    x_ld_n = 0;
    step();
    x_ld_n = 1; p_ld_n = 0;
    step();
    p_ld_n = 1;
    check_words("R3 round recaptured", 32'h00008000);
  endtask

  task automatic t_prod_hold_ft();
    load_pair(16'h1234, 0, 16'h0010, 0, 0, 1);
    x_in = 16'h0100; shr_in = 16'h0100; shr_oe_n = 1;
    x_ld_n = 0; y_ld_n = 0;
    step();
    x_ld_n = 1; y_ld_n = 1; shr_oe_n = 0;
    step();
    check_words("R6 result held", 32'h00012340);
    transparent = 1;
    check_words("R7 transparent follows", 32'h00010000);
    transparent = 0;
    check_words("R7 latched restored", 32'h00012340);
  endtask

  task automatic t_sel_oe();
    lo_sel = 1;
    #1;
    check("R8 low word on dedicated", {ded_out, shr_out}, 32'h23402340);
    ded_oe_n = 1; shr_oe_n = 1;
    #1;
    check("R9 drives off", {30'd0, ded_drv, shr_drv}, 32'd0);
    ded_oe_n = 0;
    #1;
    check("R9 dedicated on", {30'd0, ded_drv, shr_drv}, 32'd2);
    lo_sel = 0;
  endtask

  initial begin
    t_reset();
    t_arith();
    t_shift();
    t_hold_ops();
    t_round_reg();
    t_prod_hold_ft();
    t_sel_oe();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule